// File: doc/BRIEF.md
# Packet Timestamp Latch with Read-Release

This block keeps a free-running 64-bit system time and freezes a copy of it when a frame that asks for a timestamp starts. There is one copy for the transmit direction and one for the receive direction. The time advances every clock by a programmable addend, with full carry from the lower 32 bits into the upper 32 bits. Frame parsing happens outside the block. The surrounding logic drives a start-of-frame strobe for each direction, together with a per-frame flag that says the frame wants a stamp.

Each direction has a single snapshot slot. When a stamp is captured, a sticky valid flag is set and the snapshot is frozen. While the flag is set, further capture requests in that direction are dropped, so software always knows which frame the stamp belongs to. Software reads the low word first and then the high word. Reading the high word hands back the held value, clears the flag and re-arms that direction.

A plain 32-bit register port with word addresses gives access to the time, the addend, the two control words and the two snapshots.

Top module: `pkt_stamp_latch`

## Requirements
- R1: After reset, the time reads zero, both enables and both valid flags read zero, and the addend reads the parameter INC_RESET (default 1).
- R2: On every clock, the 64-bit time grows by the 32-bit addend, and the low word carries into the high word. Word addresses: 0 = time low, 1 = time high, 2 = addend (read/write).
- R3: The transmit control word is at address 4 and the receive control word is at address 8. In each, bit 4 is a read/write enable and bit 0 is the read-only valid flag. Writing bit 0 has no effect.
- R4: A start-of-frame strobe with the stamp flag set, arriving while that side is enabled and not valid, stores the time of that cycle and sets valid. Snapshot words: transmit low at 5, high at 6; receive low at 9, high at 10.
- R5: A strobe without the stamp flag, or a strobe while the side is disabled, stores nothing and leaves valid clear.
- R6: While valid is set, further capture requests on that side are ignored and the snapshot stays unchanged.
- R7: Reading the low snapshot word leaves valid set. Reading the high word returns the captured high half and clears valid.
- R8: A capture request in the same cycle as the high-word read that releases the latch is dropped. The next request after that is stamped.
- R9: Clearing the enable while valid is set keeps the held stamp and the valid flag until the high word is read.
- R10: The two directions capture and release independently of each other.
- R11: Read data appears one clock after the read strobe. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tx_sof | input | 1 | Transmit start-of-frame strobe |
| tx_stamp | input | 1 | Transmit frame wants a timestamp |
| rx_sof | input | 1 | Receive start-of-frame strobe |
| rx_stamp | input | 1 | Receive frame wants a timestamp |

## Verification
The release read of the high snapshot word and a new capture request can land in the same clock. The bench provokes this by driving a transmit start-of-frame with the stamp flag in the same cycle as the high-word read of a held stamp. The test passes when three things hold: the read returns the old captured value, the valid flag reads clear afterwards, and the next request captures the time of its own cycle, not the time of the dropped one.

// File: rtl/stamp_pkg.sv
package stamp_pkg;
  localparam int ADDR_W = 4;
  localparam int WORD_W = 32;
  localparam int TIME_W = 2 * WORD_W;
  localparam int N_SIDE = 2;            // 0 = transmit, 1 = receive
  localparam int VALID_BIT = 0;
  localparam int EN_BIT = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_TIME_LO = 4'd0,
    A_TIME_HI = 4'd1,
    A_INC     = 4'd2,
    A_TX_CTL  = 4'd4,
    A_TX_LO   = 4'd5,
    A_TX_HI   = 4'd6,
    A_RX_CTL  = 4'd8,
    A_RX_LO   = 4'd9,
    A_RX_HI   = 4'd10
  } reg_addr_e;

  // per-side base: control at base, low at base+1, high at base+2
  function automatic logic [ADDR_W-1:0] side_base(input int s);
    return ADDR_W'(4 * (s + 1));
  endfunction
endpackage

// File: rtl/stamp_time_ctr.sv
module stamp_time_ctr #(
  parameter int WORD_W = 32,
  parameter int TIME_W = 64,
  parameter logic [WORD_W-1:0] INC_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc_wr,
  input  logic [WORD_W-1:0] inc_wdata,
  output logic [WORD_W-1:0] inc,
  output logic [TIME_W-1:0] now
);
  always_ff @(posedge clk) begin
    if (rst) begin
      inc <= INC_RESET;
      now <= '0;
    end else begin
      if (inc_wr) inc <= inc_wdata;
      now <= now + TIME_W'(inc);
    end
  end

  // R2: time grows by the addend that was in place on the previous cycle
  p_advance_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> now == $past(now) + TIME_W'($past(inc)));
endmodule

// File: rtl/stamp_side.sv
module stamp_side #(
  parameter int TIME_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_wr,
  input  logic              ctl_en_wdata,
  input  logic              rd_hi,
  input  logic              sof,
  input  logic              want,
  input  logic [TIME_W-1:0] now,
  output logic              valid,
  output logic              en,
  output logic [TIME_W-1:0] snap
);
  logic cap_go;
  assign cap_go = sof && want && en && !valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      en    <= 1'b0;
      snap  <= '0;
    end else begin
      if (ctl_wr) en <= ctl_en_wdata;
      if (cap_go) begin
        snap  <= now;
        valid <= 1'b1;
      end else if (rd_hi) begin
        valid <= 1'b0;
      end
    end
  end

  // R6: a held stamp does not move
  p_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    valid |=> $stable(snap));
  // R7: high-word read frees a held stamp
  p_release_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && rd_hi) |=> !valid);
  // R4: a qualified strobe sets valid
  p_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (sof && want && en && !valid) |=> valid);
  // R5: nothing is stored while disabled
  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!en && !valid) |=> !valid);
endmodule

// File: rtl/pkt_stamp_latch.sv
module pkt_stamp_latch
  import stamp_pkg::*;
#(
  parameter logic [WORD_W-1:0] INC_RESET = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  logic              tx_sof,
  input  logic              tx_stamp,
  input  logic              rx_sof,
  input  logic              rx_stamp
);
  logic [WORD_W-1:0] inc;
  logic [TIME_W-1:0] now;
  logic [N_SIDE-1:0] sof_v, want_v, valid_v, en_v;
  logic [TIME_W-1:0] snap_v [N_SIDE];

  assign sof_v  = {rx_sof, tx_sof};
  assign want_v = {rx_stamp, tx_stamp};

  stamp_time_ctr #(.WORD_W(WORD_W), .TIME_W(TIME_W), .INC_RESET(INC_RESET)) u_ctr (
    .clk(clk), .rst(rst),
    .inc_wr(reg_wr && reg_addr == A_INC),
    .inc_wdata(reg_wdata),
    .inc(inc), .now(now)
  );

  for (genvar s = 0; s < N_SIDE; s++) begin : g_side
    localparam logic [ADDR_W-1:0] BASE = side_base(s);
    stamp_side #(.TIME_W(TIME_W)) u_side (
      .clk(clk), .rst(rst),
      .ctl_wr(reg_wr && reg_addr == BASE),
      .ctl_en_wdata(reg_wdata[EN_BIT]),
      .rd_hi(reg_rd && reg_addr == BASE + ADDR_W'(2)),
      .sof(sof_v[s]), .want(want_v[s]), .now(now),
      .valid(valid_v[s]), .en(en_v[s]), .snap(snap_v[s])
    );
  end

  logic [WORD_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      A_TIME_LO: rd_mux = now[WORD_W-1:0];
      A_TIME_HI: rd_mux = now[TIME_W-1:WORD_W];
      A_INC:     rd_mux = inc;
      default: begin
        for (int s = 0; s < N_SIDE; s++) begin
          if (reg_addr == side_base(s)) begin
            rd_mux[VALID_BIT] = valid_v[s];
            rd_mux[EN_BIT]    = en_v[s];
          end else if (reg_addr == side_base(s) + ADDR_W'(1)) begin
            rd_mux = snap_v[s][WORD_W-1:0];
          end else if (reg_addr == side_base(s) + ADDR_W'(2)) begin
            rd_mux = snap_v[s][TIME_W-1:WORD_W];
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  // R7: the high-word read returns the held value, not a live one
  p_hi_read_r7: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_TX_HI && valid_v[0]) |=>
      reg_rdata == $past(snap_v[0][TIME_W-1:WORD_W]));
  // R8: a request in the releasing cycle leaves the latch clear
  p_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == A_TX_HI && valid_v[0] && tx_sof && tx_stamp) |=> !valid_v[0]);
endmodule

// File: tb/sim_pkt_stamp_latch.sv
`timescale 1ns/1ps
module sim_pkt_stamp_latch;
  import stamp_pkg::*;
  logic clk = 0, rst = 1;
  logic reg_wr = 0, reg_rd = 0;
  logic [3:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic tx_sof = 0, tx_stamp = 0, rx_sof = 0, rx_stamp = 0;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pkt_stamp_latch u0 (.*);

  // reference time built from R1/R2
  logic [63:0] tm;
  logic [31:0] inc_m;
  always @(posedge clk) begin
    if (rst) begin tm <= 0; inc_m <= 1; end
    else begin
      tm <= tm + 64'(inc_m);
      if (reg_wr && reg_addr == 4'd2) inc_m <= reg_wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d, output logic [63:0] t_at);
    @(negedge clk); reg_rd = 1; reg_addr = a; t_at = tm;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  // one strobe; returns time of the strobe cycle
  task automatic pulse(bit rx, bit want, output logic [63:0] t_at);
    @(negedge clk);
    if (rx) begin rx_sof = 1; rx_stamp = want; end
    else begin tx_sof = 1; tx_stamp = want; end
    t_at = tm;
    @(negedge clk); rx_sof = 0; rx_stamp = 0; tx_sof = 0; tx_stamp = 0;
  endtask

  logic [31:0] d; logic [63:0] t, tc, tc2;

  task automatic t_reset();
    rd(4'd0, d, t); chk("R1 time lo", d, t[31:0]);
    rd(4'd2, d, t); chk("R1 addend", d, 32'd1);
    rd(4'd4, d, t); chk("R1 tx ctl", d, 0);
    rd(4'd8, d, t); chk("R1 rx ctl", d, 0);
    rd(4'd3, d, t); chk("R11 unmapped", d, 0);
  endtask

  task automatic t_time();
    wr(4'd2, 32'hFFFF_FFF0);
    repeat (3) @(negedge clk);
    rd(4'd0, d, t); chk("R2 time lo", d, t[31:0]);
    rd(4'd1, d, t); chk("R2 time hi", d, t[63:32]);
    chk("R2 carry reached hi", 32'(d != 0), 1);
    rd(4'd2, d, t); chk("R2 addend rw", d, 32'hFFFF_FFF0);
    wr(4'd2, 32'd3);
  endtask

  task automatic t_ctl();
    wr(4'd4, 32'h11); rd(4'd4, d, t); chk("R3 tx en, valid ro", d, 32'h10);
    wr(4'd8, 32'h11); rd(4'd8, d, t); chk("R3 rx en, valid ro", d, 32'h10);
  endtask

  task automatic t_no_req();
    pulse(0, 0, t); rd(4'd4, d, t); chk("R5 no flag no stamp", d, 32'h10);
    wr(4'd4, 0); pulse(0, 1, t); rd(4'd4, d, t); chk("R5 disabled no stamp", d, 0);
    wr(4'd4, 32'h10);
  endtask

  task automatic t_capture_frozen();
    pulse(0, 1, tc);
    rd(4'd4, d, t); chk("R4 valid set", d, 32'h11);
    pulse(0, 1, t);
    rd(4'd5, d, t); chk("R6 lo frozen", d, tc[31:0]);
    rd(4'd4, d, t); chk("R7 lo read keeps valid", d, 32'h11);
    rd(4'd6, d, t); chk("R4 hi captured", d, tc[63:32]);
    rd(4'd4, d, t); chk("R7 hi read clears", d, 32'h10);
  endtask

  task automatic t_same_cycle();
    pulse(0, 1, tc);
    @(negedge clk);
    reg_rd = 1; reg_addr = 4'd6; tx_sof = 1; tx_stamp = 1;
    @(negedge clk);
    reg_rd = 0; tx_sof = 0; tx_stamp = 0;
    chk("R8 release read old hi", reg_rdata, tc[63:32]);
    rd(4'd4, d, t); chk("R8 request dropped", d, 32'h10);
    pulse(0, 1, tc2);
    rd(4'd5, d, t); chk("R8 next stamp fresh", d, tc2[31:0]);
    rd(4'd6, d, t);
  endtask

  task automatic t_disable_hold();
    pulse(0, 1, tc);
    wr(4'd4, 0);
    rd(4'd4, d, t); chk("R9 valid kept", d, 32'h1);
    rd(4'd5, d, t); chk("R9 stamp kept", d, tc[31:0]);
    rd(4'd6, d, t); rd(4'd4, d, t); chk("R9 released", d, 0);
  endtask

  task automatic t_indep();
    pulse(1, 1, tc);
    rd(4'd4, d, t); chk("R10 tx untouched", d, 0);
    rd(4'd8, d, t); chk("R10 rx valid", d, 32'h11);
    rd(4'd9, d, t); chk("R10 rx lo", d, tc[31:0]);
    rd(4'd10, d, t); chk("R10 rx hi", d, tc[63:32]);
    rd(4'd8, d, t); chk("R10 rx released", d, 32'h10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset(); t_time(); t_ctl(); t_no_req(); t_capture_frozen();
    t_same_cycle(); t_disable_hold(); t_indep();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule